// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in, first-out store of 64 words of 8 bits each. The words are held in an internal register array, and a 6-bit stack pointer addresses them. A client asks for a push by raising `push_req` with a word on `push_data`. It asks for a pop by raising `pop_req`, and the popped word appears on `pop_data` one cycle later, with `pop_valid` marking it.

The pointer moves in a fixed order. On a push it advances first, and the word is then written at the new position. On a pop the word at the current position is read first, and the pointer then steps back. Location 0 is therefore filled last. When the 64th push wraps the pointer back to 0, the stack reports full, so every location holds data. Two flags, `full` and `empty`, track the fill level.

Some requests are illegal: a push while full, a pop while empty, and a push and a pop in the same cycle. Each of these leaves the stack untouched and raises `err` for one cycle.

Top module: `reg_stack`

## Requirements
- R1: After reset, `sp` is 0, `empty` is 1, and `full`, `err` and `pop_valid` are 0.
- R2: A legal push (push only, not full) adds 1 to `sp` on the next clock edge and clears `empty`.
- R3: A legal pop (pop only, not empty) returns the most recently pushed word that has not yet been popped. The word appears on `pop_data` with `pop_valid` high for exactly the one cycle after the request.
- R4: A legal pop subtracts 1 from `sp` and clears `full`. When the new `sp` is 0, it sets `empty`.
- R5: A push that wraps `sp` from 63 to 0 sets `full`. All 64 pushed words are then held and come back in reverse order.
- R6: A push while `full` leaves `sp`, the flags and the stored words unchanged, and `err` is 1 in the following cycle only.
- R7: A pop while `empty` leaves `sp` and the flags unchanged, does not raise `pop_valid`, and `err` is 1 in the following cycle only.
- R8: A push and a pop requested in the same cycle change nothing, and raise `err` for one cycle.
- R9: `full` and `empty` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| push_data | input | 8 | Word to push |
| pop_data | output | 8 | Last popped word, registered |
| pop_valid | output | 1 | `pop_data` updated in this cycle |
| sp | output | 6 | Stack pointer |
| full | output | 1 | All 64 locations hold data |
| empty | output | 1 | No word held |
| err | output | 1 | One-cycle pulse after an illegal request |

## Verification
The hardest state to reach is the wrapped pointer. There `sp` reads 0 while the stack is full, and location 0 holds the newest word. Getting there takes 64 pushes in a row with no pop between them. The bench fills the stack completely with distinct values, then pushes once more into the full stack to prove that nothing is overwritten. It then drains all 64 words and checks each one against its expected position in reverse order, which also covers the transition from full back to empty.

// File: rtl/reg_stack.sv
module reg_stack #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] pop_data,
  output logic          pop_valid,
  output logic [AW-1:0] sp,
  output logic          full,
  output logic          empty,
  output logic          err
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  wire          do_push = push_req & ~pop_req & ~full;
  wire          do_pop  = pop_req & ~push_req & ~empty;
  wire          bad     = (push_req & pop_req) | (push_req & full) | (pop_req & empty);
  wire [AW-1:0] sp_up   = sp + 1'b1;
  wire [AW-1:0] sp_dn   = sp - 1'b1;

  always_ff @(posedge clk) begin
    if (do_push) mem[sp_up] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp        <= '0;
      full      <= 1'b0;
      empty     <= 1'b1;
      err       <= 1'b0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
    end else begin
      err       <= bad;
      pop_valid <= do_pop;
      if (do_push) begin
        sp    <= sp_up;
        empty <= 1'b0;
        if (sp_up == '0) full <= 1'b1;
      end else if (do_pop) begin
        pop_data <= mem[sp];
        sp       <= sp_dn;
        full     <= 1'b0;
        if (sp_dn == '0) empty <= 1'b1;
      end
    end
  end

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !full) |=> (sp == AW'($past(sp) + 1'b1)) && !empty);

  // R3
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !empty) |=> pop_valid);

  // R6
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && full) |=> err && $stable(sp) && full);

  // R7
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && empty) |=> err && $stable(sp) && !pop_valid);

  // R8
  both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |=> err && $stable(sp) && !pop_valid);
endmodule

// File: tb/tb_reg_stack.sv
`timescale 1ns/1ps
module tb_reg_stack;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_req = 1'b0, pop_req = 1'b0;
  logic [7:0] push_data = '0;
  logic [7:0] pop_data;
  logic       pop_valid, full, empty, err;
  logic [5:0] sp;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  reg_stack dut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .pop_data(pop_data), .pop_valid(pop_valid),
    .sp(sp), .full(full), .empty(empty), .err(err)
  );

  // {push, pop, din[8], valid, dout[8], sp[6], empty, full, err}
  localparam logic [27:0] VEC [12] = '{
    {1'b1, 1'b0, 8'hA1, 1'b0, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hB2, 1'b0, 8'h00, 6'd2, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hC3, 1'b0, 8'h00, 6'd3, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b1, 8'hC3, 6'd2, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hD4, 1'b0, 8'h00, 6'd3, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b1, 8'hD4, 6'd2, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b1, 8'hB2, 6'd1, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b1, 8'hA1, 6'd0, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 6'd0, 1'b1, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h77, 1'b0, 8'h00, 6'd0, 1'b1, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h55, 1'b0, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b1, 8'h55, 6'd0, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic [7:0] d);
    push_req = pu; pop_req = po; push_data = d;
    @(posedge clk);
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    check("R9 flags exclusive", {31'd0, full & empty}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sp", {26'd0, sp}, 32'd0);
    check("R1 empty", {31'd0, empty}, 32'd1);
    check("R1 full", {31'd0, full}, 32'd0);
    check("R1 err", {31'd0, err}, 32'd0);
    check("R1 pop_valid", {31'd0, pop_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [27:0] v;
      v = VEC[i];
      step(v[27], v[26], v[25:18]);
      check("R2/R4 sp", {26'd0, sp}, {26'd0, v[8:3]});
      check("R2/R4 empty", {31'd0, empty}, {31'd0, v[2]});
      check("R5 full", {31'd0, full}, {31'd0, v[1]});
      check("R6/R7/R8 err", {31'd0, err}, {31'd0, v[0]});
      check("R3 pop_valid", {31'd0, pop_valid}, {31'd0, v[17]});
      if (v[17]) check("R3 pop_data", {24'd0, pop_data}, {24'd0, v[16:9]});
    end

    for (int i = 1; i <= 64; i++) begin
      step(1'b1, 1'b0, 8'(i + 8'h10));
      if (i == 63) begin
        check("R5 sp at 63", {26'd0, sp}, 32'd63);
        check("R5 not full at 63", {31'd0, full}, 32'd0);
      end
    end
    check("R5 wrap sp", {26'd0, sp}, 32'd0);
    check("R5 full set", {31'd0, full}, 32'd1);
    check("R5 empty clear", {31'd0, empty}, 32'd0);

    step(1'b1, 1'b0, 8'hEE);
    check("R6 err", {31'd0, err}, 32'd1);
    check("R6 sp", {26'd0, sp}, 32'd0);
    check("R6 full", {31'd0, full}, 32'd1);
    step(1'b0, 1'b0, 8'h00);
    check("R6 err one cycle", {31'd0, err}, 32'd0);

    step(1'b1, 1'b1, 8'hEE);
    check("R8 err while full", {31'd0, err}, 32'd1);
    check("R8 full kept", {31'd0, full}, 32'd1);

    for (int i = 64; i >= 1; i--) begin
      step(1'b0, 1'b1, 8'h00);
      check("R5 drain data", {24'd0, pop_data}, 32'(i + 8'h10));
      check("R3 drain valid", {31'd0, pop_valid}, 32'd1);
      check("R4 drain sp", {26'd0, sp}, 32'(i - 1));
      if (i == 64) check("R4 full cleared", {31'd0, full}, 32'd0);
      if (i > 1) check("R4 not empty", {31'd0, empty}, 32'd0);
    end
    check("R4 empty at end", {31'd0, empty}, 32'd1);
    step(1'b0, 1'b0, 8'h00);
    check("R3 valid one cycle", {31'd0, pop_valid}, 32'd0);
    check("R3 data held", {24'd0, pop_data}, 32'h11);

    step(1'b0, 1'b1, 8'h00);
    check("R7 err", {31'd0, err}, 32'd1);
    check("R7 no valid", {31'd0, pop_valid}, 32'd0);
    check("R7 data held", {24'd0, pop_data}, 32'h11);
    step(1'b0, 1'b0, 8'h00);
    check("R7 err one cycle", {31'd0, err}, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule